// File: doc/BRIEF.md
# Remote Wakeup Resume Sequencer

This block times the resume signal that a suspended USB device sends to wake its host. Once firmware sets the wake request, the sequencer first keeps the bus idle for a lead interval. It then asserts the enable that makes the line driver hold the K state for a fixed time. At the end of that time it sends a one-cycle completion strobe into the interrupt logic. If the request is still set when the quiet gap after completion runs out, a new K-state burst starts. This repeats until firmware clears the request.

All intervals are counted in ticks of a 1 ms timebase input, and the counts are parameters. If the device is powered down when the request arrives, the sequencer first asks for the oscillator. It waits until a synchronised oscillator-stable report arrives, and only then starts the timed lead interval. The oscillator request stays asserted for as long as any phase of the sequence is active.

Top module: `rsq_wakeup_seq`

## Requirements
- R1: A synchronous active-high reset drives the K-state enable, the oscillator request and the done strobe low at the next clock edge, even in the middle of a K state, and the block stays idle until the wake request is seen again.
- R2: With power-down low, a wake request seen at a clock edge starts the lead interval. The K-state enable rises at the edge that carries the LEAD_TICKS-th tick counted after that edge.
- R3: Once started, the K-state enable stays high for exactly K ticks, from one tick edge to the K-th tick edge after it. Changes of the wake request or of power-down during that time do not shorten or lengthen it.
- R4: The done strobe is high for exactly one clock cycle, in the first cycle after the K-state enable falls. It is never high in two consecutive cycles.
- R5: After each K state the bus stays quiet for GAP_TICKS ticks. If the wake request is high at the tick that ends this gap, a new K state starts at that same edge. Otherwise the block returns to idle.
- R6: Clearing the wake request during the lead interval or the K state cancels neither. The K state and its done strobe still occur.
- R7: If power-down is high when a wake request starts a sequence, the oscillator request rises and the lead interval is held off until the oscillator-stable input, passed through SYNC_STAGES flip-flops, reads high.
- R8: The oscillator request is high in every non-idle phase, including the whole K state, and is low in idle.
- R9: The K length in ticks is K_TICKS limited to the resume window of 1 to 15 ticks. A K_TICKS of 20 gives a K state of 15 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | 1 | Firmware wake request level |
| pwr_down | input | 1 | Device is in its powered-down state |
| osc_stable | input | 1 | Oscillator reports stable (asynchronous) |
| tick_ms | input | 1 | One-cycle pulse per 1 ms of timebase |
| k_drive | output | 1 | Enable for the line driver to hold the K state |
| osc_en_req | output | 1 | Request to keep or restart the oscillator |
| done_strobe | output | 1 | One-cycle completion set pulse to the interrupt logic |

## Verification
Every state change happens at the clock edge that carries the wake request, the synchronised stable flag or a counted tick. The outputs come from registers, so each result shows one edge after its cause. The bench holds the tick period at four cycles and raises each stimulus just after a tick edge. This keeps the request edge and the synchroniser delay clear of any counted tick. At each falling clock edge the bench samples the outputs and counts the ticks and the high and low cycles. It expects the K rise after exactly LEAD_TICKS ticks, K runs of K×4 cycles, gaps of GAP_TICKS×4 cycles and the done strobe in the cycle of the K fall.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // Phases of the resume sequence
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OSC  = 3'd1,
        ST_LEAD = 3'd2,
        ST_KDRV = 3'd3,
        ST_GAP  = 3'd4
    } rsq_state_e;

    // Registered outputs of the controller
    typedef struct packed {
        logic k_drive;
        logic osc_en;
        logic done;
    } rsq_out_t;

    // Resume signalling window in ticks
    localparam int unsigned K_MIN_TICKS = 1;
    localparam int unsigned K_MAX_TICKS = 15;

    function automatic int unsigned clamp_k(input int unsigned want);
        if (want < K_MIN_TICKS) return K_MIN_TICKS;
        if (want > K_MAX_TICKS) return K_MAX_TICKS;
        return want;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned width_for(input int unsigned top);
        return (top < 2) ? 1 : $clog2(top + 1);
    endfunction

endpackage

// File: rtl/rsq_osc_sync.sv
module rsq_osc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stable_async,
    output logic stable_sync
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= stable_async;
            end
            assign stable_sync = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= {q[STAGES-2:0], stable_async};
            end
            assign stable_sync = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rsq_tick_timer.sv
module rsq_tick_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    assign expire = run && tick && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear)      cnt_q <= '0;
        else if (run && tick)  cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < limit)); // R3
endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
    import rsq_pkg::*;
#(
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned LEAD_TICKS = 5,
    parameter int unsigned KDRV_TICKS = 10,
    parameter int unsigned GAP_TICKS  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wake_req,
    input  logic             pwr_down,
    input  logic             osc_ok,
    input  logic             expire,
    output logic             clear,
    output logic             run,
    output logic [CNT_W-1:0] limit,
    output rsq_out_t         out
);
    rsq_state_e state_q, state_d;
    logic       fin;
    logic       done_q;

    always_comb begin
        state_d = state_q;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (wake_req) state_d = pwr_down ? ST_OSC : ST_LEAD;
            ST_OSC:  if (osc_ok)   state_d = ST_LEAD;
            ST_LEAD: if (expire)   state_d = ST_KDRV;
            ST_KDRV: if (expire) begin
                state_d = ST_GAP;
                fin     = 1'b1;
            end
            ST_GAP:  if (expire)   state_d = wake_req ? ST_KDRV : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_LEAD: limit = CNT_W'(LEAD_TICKS);
            ST_KDRV: limit = CNT_W'(KDRV_TICKS);
            ST_GAP:  limit = CNT_W'(GAP_TICKS);
            default: limit = CNT_W'(1);
        endcase
    end

    assign clear = (state_d != state_q);
    assign run   = (state_q == ST_LEAD) || (state_q == ST_KDRV) || (state_q == ST_GAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= fin;
        end
    end

    assign out.k_drive = (state_q == ST_KDRV);
    assign out.osc_en  = (state_q != ST_IDLE);
    assign out.done    = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out.done |=> !out.done); // R4
    AST_DONE_AT_K_END: assert property (@(posedge clk) disable iff (rst)
        out.done |-> (!out.k_drive && $past(out.k_drive))); // R4
    AST_K_WITH_OSC: assert property (@(posedge clk) disable iff (rst)
        out.k_drive |-> out.osc_en); // R8
    AST_K_FROM_TIMER: assert property (@(posedge clk) disable iff (rst)
        $rose(out.k_drive) |-> $past(expire)); // R2
    AST_OSC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OSC && !osc_ok) |=> (state_q == ST_OSC)); // R7
    AST_K_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_KDRV && !expire) |=> out.k_drive); // R3
endmodule

// File: rtl/rsq_wakeup_seq.sv
module rsq_wakeup_seq
    import rsq_pkg::*;
#(
    parameter int unsigned LEAD_TICKS  = 5,
    parameter int unsigned K_TICKS     = 10,
    parameter int unsigned GAP_TICKS   = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wake_req,
    input  logic pwr_down,
    input  logic osc_stable,
    input  logic tick_ms,
    output logic k_drive,
    output logic osc_en_req,
    output logic done_strobe
);
    localparam int unsigned K_EFF   = clamp_k(K_TICKS);
    localparam int unsigned TOP_CNT = max3(LEAD_TICKS, K_EFF, GAP_TICKS);
    localparam int unsigned CNT_W   = width_for(TOP_CNT);

    logic             osc_ok;
    logic             expire;
    logic             clear;
    logic             run;
    logic [CNT_W-1:0] limit;
    rsq_out_t         out;

    rsq_osc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .stable_async (osc_stable),
        .stable_sync  (osc_ok)
    );

    rsq_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .run    (run),
        .tick   (tick_ms),
        .limit  (limit),
        .expire (expire)
    );

    rsq_ctrl #(
        .CNT_W      (CNT_W),
        .LEAD_TICKS (LEAD_TICKS),
        .KDRV_TICKS (K_EFF),
        .GAP_TICKS  (GAP_TICKS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wake_req (wake_req),
        .pwr_down (pwr_down),
        .osc_ok   (osc_ok),
        .expire   (expire),
        .clear    (clear),
        .run      (run),
        .limit    (limit),
        .out      (out)
    );

    assign k_drive     = out.k_drive;
    assign osc_en_req  = out.osc_en;
    assign done_strobe = out.done;
endmodule

// File: tb/test_rsq_wakeup_seq.sv
`timescale 1ns/100ps
module test_rsq_wakeup_seq;
    localparam int TP    = 4;
    localparam int LEAD  = 5;
    localparam int KT    = 10;
    localparam int GAP   = 5;
    localparam int KBIG  = 20;
    localparam int KCLMP = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wake_req = 1'b0;
    logic pwr_down = 1'b0;
    logic osc_stable = 1'b0;
    logic tick = 1'b0;
    logic k_drive, osc_en_req, done_strobe;
    logic k2, osc2, done2;

    always #2.5 clk = ~clk;

    rsq_wakeup_seq i_rsq_wakeup_seq (
        .clk(clk), .rst(rst), .wake_req(wake_req), .pwr_down(pwr_down),
        .osc_stable(osc_stable), .tick_ms(tick),
        .k_drive(k_drive), .osc_en_req(osc_en_req), .done_strobe(done_strobe)
    );

    rsq_wakeup_seq #(.K_TICKS(KBIG)) i_rsq_wakeup_seq_clamp (
        .clk(clk), .rst(rst), .wake_req(wake_req), .pwr_down(pwr_down),
        .osc_stable(osc_stable), .tick_ms(tick),
        .k_drive(k2), .osc_en_req(osc2), .done_strobe(done2)
    );

    int  n_chk = 0, n_bad = 0;
    int  cyc = 0;
    bit  tick_at_edge = 0;
    bit  finished = 0;
    int  ticks_since = 0, rise_ticks = 0;
    int  rises = 0, falls = 0, dones = 0, done_wide = 0;
    int  k_len = 0, k_last = 0, low_len = 0, gap_last = 0;
    bit  k_prev = 0, done_prev = 0, done_at_fall = 0;
    int  k2_len = 0, k2_last = 0;
    bit  k2_prev = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic observe();
        if (tick_at_edge) ticks_since++;
        if (k_drive && !k_prev) begin
            rises++; rise_ticks = ticks_since; gap_last = low_len; k_len = 0;
        end
        if (k_drive) k_len++; else low_len++;
        if (!k_drive && k_prev) begin
            falls++; k_last = k_len; low_len = 1; done_at_fall = done_strobe;
        end
        if (done_strobe) begin
            dones++;
            if (done_prev) done_wide++;
        end
        k_prev = k_drive; done_prev = done_strobe;
        if (k2 && !k2_prev) k2_len = 0;
        if (k2) k2_len++;
        if (!k2 && k2_prev) k2_last = k2_len;
        k2_prev = k2;
    endtask

    task automatic step();
        @(posedge clk);
        tick_at_edge = tick;
        #1;
        cyc++;
        tick = ((cyc % TP) == 0);
        @(negedge clk);
        observe();
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic align();
        do step(); while (!tick_at_edge);
    endtask

    task automatic wait_rise(input string req);
        int start = rises;
        int n = 0;
        while (rises == start && n < 400) begin step(); n++; end
        chk(rises != start, req, n, -1);
    endtask

    task automatic wait_fall(input string req);
        int start = falls;
        int n = 0;
        while (falls == start && n < 400) begin step(); n++; end
        chk(falls != start, req, n, -1);
    endtask

    initial begin
        #(20000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int d0, r0;
        steps(3);
        // R1: reset state
        chk(k_drive == 1'b0, "R1 k after reset", k_drive, 0);
        chk(osc_en_req == 1'b0, "R1 osc after reset", osc_en_req, 0);
        chk(done_strobe == 1'b0, "R1 done after reset", done_strobe, 0);
        rst = 1'b0;
        steps(4);

        // Basic sequence, request dropped right after K starts
        align(); wake_req = 1'b1; ticks_since = 0;
        step();
        chk(osc_en_req == 1'b1, "R8 osc during lead", osc_en_req, 1);
        wait_rise("R2 k rise");
        chk(rise_ticks == LEAD, "R2 lead ticks", rise_ticks, LEAD);
        chk(osc_en_req == 1'b1, "R8 osc during K", osc_en_req, 1);
        wake_req = 1'b0;
        d0 = dones;
        wait_fall("R3 k fall");
        chk(k_last == KT * TP, "R3 K length", k_last, KT * TP);
        chk(done_at_fall == 1'b1, "R4 done at K end", done_at_fall, 1);
        r0 = rises;
        steps(30);
        chk(rises == r0, "R5 no repeat after clear", rises - r0, 0);
        chk(osc_en_req == 1'b0, "R8 osc idle", osc_en_req, 0);
        chk(dones - d0 == 1, "R4 one done", dones - d0, 1);
        chk(k2_last == KCLMP * TP, "R9 clamped K length", k2_last, KCLMP * TP);

        // Looping while request held
        align(); wake_req = 1'b1; ticks_since = 0;
        d0 = dones; r0 = rises;
        for (int i = 0; i < 3; i++) begin
            wait_rise("R5 loop rise");
            if (i > 0) chk(gap_last == GAP * TP, "R5 gap length", gap_last, GAP * TP);
            wait_fall("R5 loop fall");
            chk(k_last == KT * TP, "R3 loop K length", k_last, KT * TP);
        end
        wake_req = 1'b0;
        steps(30);
        chk(rises - r0 == 3, "R5 loop count", rises - r0, 3);
        chk(dones - d0 == 3, "R4 loop dones", dones - d0, 3);

        // Request cleared during lead interval
        align(); wake_req = 1'b1; ticks_since = 0;
        steps(8);
        wake_req = 1'b0;
        wait_rise("R6 rise after early clear");
        chk(rise_ticks == LEAD, "R6 lead kept", rise_ticks, LEAD);
        wait_fall("R6 fall");
        chk(k_last == KT * TP, "R6 K kept", k_last, KT * TP);
        steps(30);

        // Power-down toggled during K
        align(); wake_req = 1'b1; ticks_since = 0;
        wait_rise("R3 rise");
        wake_req = 1'b0;
        steps(10);
        pwr_down = 1'b1;
        wait_fall("R3 fall");
        chk(k_last == KT * TP, "R3 K with pwr_down change", k_last, KT * TP);
        pwr_down = 1'b0;
        steps(30);

        // Start from powered down
        pwr_down = 1'b1; osc_stable = 1'b0;
        align(); wake_req = 1'b1;
        r0 = rises;
        steps(60);
        chk(rises == r0, "R7 held for oscillator", rises - r0, 0);
        chk(osc_en_req == 1'b1, "R7 osc requested", osc_en_req, 1);
        align(); osc_stable = 1'b1; ticks_since = 0;
        wait_rise("R7 rise after stable");
        chk(rise_ticks == LEAD, "R7 lead after stable", rise_ticks, LEAD);
        wake_req = 1'b0; pwr_down = 1'b0;
        wait_fall("R7 fall");
        steps(30);
        osc_stable = 1'b0;

        // Reset in the middle of K
        align(); wake_req = 1'b1;
        wait_rise("R1 rise before reset");
        steps(3);
        rst = 1'b1;
        step();
        chk(k_drive == 1'b0, "R1 k off after reset", k_drive, 0);
        chk(osc_en_req == 1'b0, "R1 osc off after reset", osc_en_req, 0);
        chk(done_strobe == 1'b0, "R1 no done on reset", done_strobe, 0);
        wake_req = 1'b0; rst = 1'b0;
        steps(30);
        chk(k_drive == 1'b0 && osc_en_req == 1'b0, "R1 stays idle",
            {k_drive, osc_en_req}, 0);

        chk(done_wide == 0, "R4 done width", done_wide, 0);
        finished = 1;
        summary();
        $finish;
    end
endmodule